// File: doc/BRIEF.md
# Two-Page Chip-Select Decoder for a 16-Bit Memory Bank

This block sits between a processor with a 24-bit byte address and a 16-bit memory bank built from pairs of 8-bit-wide static devices. The processor supplies an active-low address qualifier and separate active-low read and write strobes. The upper nine address bits name one of 512 pages of 32K locations each. Only two of those pages hold memory. The block turns the page number and the strobes into one active-low select for each populated page, plus a shared active-low output enable and a shared active-low write enable. The low fifteen address bits go straight to every device.

Two 8-bit devices make up each populated page. Both devices in a page share that page's select. One device holds data bits 7..0 and the other holds bits 15..8. The block includes a cycle-based model of the devices, so the whole path can be checked from the processor side.

A device stores a word when its write enable returns high, using the address and data it held on the last clock edge before that. A device drives read data only while it is selected, its output is enabled and its write enable is high. The model keeps only a parameterised number of low offset bits. It folds the remaining offset bits onto its index with an exclusive OR.

Top module: `paged_mem_decoder`

## Requirements
- R1: The page number is address bits 23..15. The page set by parameter PAGE_A (default 0) drives csN[0] low, and the page set by PAGE_B (default 1) drives csN[1] low. Only one select is low at a time.
- R2: An address in any other page leaves csN at 2'b11, leaves oeN and weN high, and returns rdData of zero.
- R3: While addrValidN is high, csN stays 2'b11 and both oeN and weN stay high, whatever the strobes do.
- R4: A read has addrValidN low, rdN low and wrN high, and targets a populated page. During a read, that page's select and oeN are low and weN is high. In the same cycle, rdData holds the stored word at the offset.
- R5: A write has addrValidN low, wrN low and rdN high, and targets a populated page. During a write, that page's select and weN are low and oeN is high.
- R6: A written word is committed at the first clock edge that samples weN high after an edge that sampled it low. A read in the cycle between those two edges returns the old word. A read after the commit edge returns the new word.
- R7: If wrN is held low across several edges while the address and data change, only the address and data sampled at the last low edge are stored. The earlier locations keep their contents.
- R8: If rdN and wrN are both low, protoErr is high, csN is 2'b11 and both oeN and weN are high. Such a cycle stores nothing. At all other times, protoErr is low.
- R9: rdData[7..0] comes from the low-lane device and rdData[15..8] from the high-lane device. A write stores both bytes.
- R10: Reset clears every stored word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the device model |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 24 | Processor byte address: page in bits 23..15, offset in bits 14..0 |
| addrValidN | input | 1 | Active-low address qualifier |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| wrData | input | 16 | Write data from the processor |
| rdData | output | 16 | Read data to the processor; zero when nothing drives |
| csN | output | 2 | Active-low select, one bit per populated page |
| oeN | output | 1 | Shared active-low output enable |
| weN | output | 1 | Shared active-low write enable |
| protoErr | output | 1 | High while both strobes are low together |

## Verification
The selects, the enables, protoErr and rdData are combinational in the inputs and the stored contents. The bench therefore drives inputs just after a falling edge and samples them one nanosecond later, in the same cycle. A stored word changes only at the rising edge that sees weN high after a low sample, so every write is followed by one release cycle before any read that expects the new word. The R6 check reads once inside that release cycle, where it expects the old word, and once after the commit edge, where it expects the new one.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;
  localparam int NUM_PAGES = 2;

  typedef struct packed {
    logic [NUM_PAGES-1:0] csN;
    logic                 oeN;
    logic                 weN;
  } strobes_t;
endpackage

// File: rtl/pgdec_ctrl.sv
module pgdec_ctrl
  import pgdec_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int PAGE_A = 0,
  parameter int PAGE_B = 1
) (
  input  logic [PAGE_W-1:0] pageNum,
  input  logic              addrValidN,
  input  logic              rdN,
  input  logic              wrN,
  output strobes_t          strobes,
  output logic              protoErr
);
  localparam logic [NUM_PAGES-1:0][PAGE_W-1:0] PAGE_IDS =
    {PAGE_W'(PAGE_B), PAGE_W'(PAGE_A)};

  logic [NUM_PAGES-1:0] hit;
  logic rdReq, wrReq, oneStrobe, anyHit;

  // Match the page number against each populated page.
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_match
    assign hit[p] = !addrValidN && (pageNum == PAGE_IDS[p]);
  end

  always_comb begin
    rdReq     = !rdN;
    wrReq     = !wrN;
    oneStrobe = rdReq ^ wrReq;
    anyHit    = |hit;
    protoErr  = rdReq && wrReq;
    for (int p = 0; p < NUM_PAGES; p++) begin
      strobes.csN[p] = !(hit[p] && oneStrobe);
    end
    strobes.oeN = !(anyHit && rdReq && !wrReq);
    strobes.weN = !(anyHit && wrReq && !rdReq);
  end
endmodule

// File: rtl/pgdec_byte_dev.sv
module pgdec_byte_dev #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          oeN,
  input  logic          weN,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          drive
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    cells [DEPTH];
  logic          pend;
  logic [AW-1:0] pAddr;
  logic [7:0]    pData;

  // Hold address and data while the write enable is low.
  // Commit them on the first edge that finds the write enable high again.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend  <= 1'b0;
      pAddr <= '0;
      pData <= '0;
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (!csN && !weN) begin
      pend  <= 1'b1;
      pAddr <= addr;
      pData <= din;
    end else if (pend) begin
      cells[pAddr] <= pData;
      pend         <= 1'b0;
    end
  end

  assign drive = !csN && !oeN && weN;
  assign dout  = drive ? cells[addr] : 8'h00;
endmodule

// File: rtl/pgdec_bank.sv
module pgdec_bank
  import pgdec_pkg::*;
#(
  parameter int OFF_W      = 15,
  parameter int DATA_W     = 16,
  parameter int MODEL_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobes,
  input  logic [OFF_W-1:0]     offset,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_PAGES-1:0] pageDrive
);
  localparam int LANES = DATA_W / 8;
  localparam int UP_W  = OFF_W - MODEL_BITS;

  logic [MODEL_BITS-1:0] devAddr;
  logic [NUM_PAGES-1:0][LANES-1:0][7:0] laneOut;
  logic [NUM_PAGES-1:0][LANES-1:0]      laneDrive;

  if (UP_W > 0) begin : g_fold
    assign devAddr = offset[MODEL_BITS-1:0] ^ MODEL_BITS'(offset[OFF_W-1:MODEL_BITS]);
  end else begin : g_direct
    assign devAddr = offset[MODEL_BITS-1:0];
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      pgdec_byte_dev #(.AW(MODEL_BITS)) u_dev (
        .clk  (clk),
        .rstN (rstN),
        .csN  (strobes.csN[p]),
        .oeN  (strobes.oeN),
        .weN  (strobes.weN),
        .addr (devAddr),
        .din  (wrData[l*8 +: 8]),
        .dout (laneOut[p][l]),
        .drive(laneDrive[p][l])
      );
    end
    assign pageDrive[p] = laneDrive[p][0];
  end

  // Shared bus: undriven lanes return zero, so an OR merges the pages.
  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      for (int l = 0; l < LANES; l++) begin
        rdData[l*8 +: 8] = rdData[l*8 +: 8] | laneOut[p][l];
      end
    end
  end
endmodule

// File: rtl/paged_mem_decoder.sv
module paged_mem_decoder
  import pgdec_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int OFF_W      = 15,
  parameter int DATA_W     = 16,
  parameter int PAGE_A     = 0,
  parameter int PAGE_B     = 1,
  parameter int MODEL_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 addrValidN,
  input  logic                 rdN,
  input  logic                 wrN,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_PAGES-1:0] csN,
  output logic                 oeN,
  output logic                 weN,
  output logic                 protoErr
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  strobes_t             strobes;
  logic [NUM_PAGES-1:0] pageDrive;

  pgdec_ctrl #(.PAGE_W(PAGE_W), .PAGE_A(PAGE_A), .PAGE_B(PAGE_B)) u_ctrl (
    .pageNum   (cpuAddr[ADDR_W-1:OFF_W]),
    .addrValidN(addrValidN),
    .rdN       (rdN),
    .wrN       (wrN),
    .strobes   (strobes),
    .protoErr  (protoErr)
  );

  pgdec_bank #(.OFF_W(OFF_W), .DATA_W(DATA_W), .MODEL_BITS(MODEL_BITS)) u_bank (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .offset   (cpuAddr[OFF_W-1:0]),
    .wrData   (wrData),
    .rdData   (rdData),
    .pageDrive(pageDrive)
  );

  assign csN = strobes.csN;
  assign oeN = strobes.oeN;
  assign weN = strobes.weN;
endmodule

// File: rtl/pgdec_checker.sv
module pgdec_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrValidN,
  input logic              rdN,
  input logic              wrN,
  input logic [1:0]        csN,
  input logic              oeN,
  input logic              weN,
  input logic              protoErr,
  input logic [DATA_W-1:0] rdData,
  input logic [1:0]        pageDrive
);
  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_valid_gates_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrValidN |-> (csN == 2'b11 && oeN && weN));

  assert_enable_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> weN);

  assert_conflict_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !wrN) |-> (protoErr && csN == 2'b11 && oeN && weN));

  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csN == 2'b11) |-> (rdData == '0 && pageDrive == 2'b00));

  assert_single_driver_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pageDrive));
endmodule

bind paged_mem_decoder pgdec_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addrValidN(addrValidN),
  .rdN       (rdN),
  .wrN       (wrN),
  .csN       (csN),
  .oeN       (oeN),
  .weN       (weN),
  .protoErr  (protoErr),
  .rdData    (rdData),
  .pageDrive (pageDrive)
);

// File: tb/sim_paged_mem_decoder.sv
`timescale 1ns/1ps
module sim_paged_mem_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic        addrValidN = 1'b1;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  csN;
  logic        oeN, weN, protoErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  paged_mem_decoder u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .addrValidN(addrValidN),
    .rdN(rdN), .wrN(wrN), .wrData(wrData), .rdData(rdData),
    .csN(csN), .oeN(oeN), .weN(weN), .protoErr(protoErr)
  );

  function automatic logic [15:0] pat(int pg, int off);
    logic [7:0] lo, hi;
    lo = 8'(off * 7 + pg * 91 + 3);
    hi = 8'(off * 13 + pg * 45 + 200);
    return {hi, lo};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive after a falling edge, let combinational outputs settle.
  task automatic drive(int pg, int off, bit av, bit rd, bit wr, logic [15:0] d);
    @(negedge clk);
    cpuAddr    = {9'(pg), 15'(off)};
    addrValidN = ~av;
    rdN        = ~rd;
    wrN        = ~wr;
    wrData     = d;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 1'b0, 1'b0, 1'b0, 16'h0000);
  endtask

  function automatic logic [1:0] expCs(int pg);
    if (pg == 0) return 2'b10;
    if (pg == 1) return 2'b01;
    return 2'b11;
  endfunction

  task automatic writeWord(int pg, int off, logic [15:0] d);
    drive(pg, off, 1'b1, 1'b0, 1'b1, d);
    chk(csN == expCs(pg) && !weN && oeN, "R5", {29'd0, csN, weN}, {29'd0, expCs(pg), 1'b0});
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R10: contents zero after reset; R4 read strobes on page 1
    drive(1, 3, 1'b1, 1'b1, 1'b0, 16'h0);
    chk(rdData == 16'h0000, "R10", {16'd0, rdData}, 32'd0);
    chk(csN == 2'b01 && !oeN && weN, "R4", {30'd0, csN}, 32'd1);
    chk(!protoErr, "R8", {31'd0, protoErr}, 32'd0);

    // R1 R2: read sweep over every page
    for (int pg = 0; pg < 512; pg++) begin
      drive(pg, pg & 255, 1'b1, 1'b1, 1'b0, 16'h0);
      chk(csN == expCs(pg), "R1", {30'd0, csN}, {30'd0, expCs(pg)});
      chk(oeN == (pg > 1) && weN, "R2", {30'd0, oeN, weN}, {30'd0, (pg > 1), 1'b1});
      if (pg > 1) chk(rdData == 16'h0, "R2", {16'd0, rdData}, 32'd0);
    end

    // R3: qualifier high blocks everything
    for (int k = 0; k < 4; k++) begin
      drive(k & 1, k, 1'b0, k < 2, k >= 2, 16'hFFFF);
      chk(csN == 2'b11 && oeN && weN, "R3", {29'd0, csN, oeN}, {29'd0, 2'b11, 1'b1});
    end

    // Fill both pages
    for (int pg = 0; pg < 2; pg++)
      for (int off = 0; off < 256; off++) writeWord(pg, off, pat(pg, off));

    // R4 R9: read back with lane split
    for (int pg = 0; pg < 2; pg++)
      for (int off = 0; off < 256; off++) begin
        drive(pg, off, 1'b1, 1'b1, 1'b0, 16'h0);
        chk(rdData[7:0] == pat(pg, off)[7:0], "R9", {24'd0, rdData[7:0]}, {24'd0, pat(pg, off)[7:0]});
        chk(rdData[15:8] == pat(pg, off)[15:8], "R4", {24'd0, rdData[15:8]}, {24'd0, pat(pg, off)[15:8]});
      end

    // R6: read inside the release cycle sees old word, later sees new
    drive(0, 40, 1'b1, 1'b0, 1'b1, 16'hBEEF);
    drive(0, 40, 1'b1, 1'b1, 1'b0, 16'h0);
    chk(rdData == pat(0, 40), "R6", {16'd0, rdData}, {16'd0, pat(0, 40)});
    drive(0, 40, 1'b1, 1'b1, 1'b0, 16'h0);
    chk(rdData == 16'hBEEF, "R6", {16'd0, rdData}, 32'h0000BEEF);

    // R7: strobe held across three edges; only the last sample is stored
    drive(1, 10, 1'b1, 1'b0, 1'b1, 16'h1111);
    drive(1, 11, 1'b1, 1'b0, 1'b1, 16'h2222);
    drive(1, 12, 1'b1, 1'b0, 1'b1, 16'h3333);
    idle();
    drive(1, 10, 1'b1, 1'b1, 1'b0, 16'h0);
    chk(rdData == pat(1, 10), "R7", {16'd0, rdData}, {16'd0, pat(1, 10)});
    drive(1, 11, 1'b1, 1'b1, 1'b0, 16'h0);
    chk(rdData == pat(1, 11), "R7", {16'd0, rdData}, {16'd0, pat(1, 11)});
    drive(1, 12, 1'b1, 1'b1, 1'b0, 16'h0);
    chk(rdData == 16'h3333, "R7", {16'd0, rdData}, 32'h00003333);

    // R8: both strobes low
    drive(0, 50, 1'b1, 1'b1, 1'b1, 16'h7777);
    chk(protoErr && csN == 2'b11 && oeN && weN, "R8", {28'd0, protoErr, csN, weN}, {28'd0, 1'b1, 2'b11, 1'b1});
    idle();
    drive(0, 50, 1'b1, 1'b1, 1'b0, 16'h0);
    chk(rdData == pat(0, 50), "R8", {16'd0, rdData}, {16'd0, pat(0, 50)});
    chk(!protoErr, "R8", {31'd0, protoErr}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule